// File: doc/BRIEF.md
# Reloading 16-bit Down Timer with Byte Register Access

This block is a 16-bit down counter paired with a 16-bit reload latch, reached by software through an 8-bit register port. The low and high halves of the count appear at separate addresses. Reads and writes follow a fixed byte order, so a 16-bit value moves as one coherent quantity. A read of the high byte captures the low byte at the same instant. A write of the low byte is parked in a holding register until the high byte arrives, and then both halves are committed together. A mode register selects the count source, which is either the clock divided by 16 or active edges on a counter pin input. It also selects which pin edge is active, whether a commit goes to the latch alone or to the latch and counter together, whether counting is halted, and whether the pulse output is driven.

Each active count pulse decrements the counter. A pulse that arrives while the counter holds zero is an underflow: the latch value is reloaded, a sticky interrupt request is raised, and in pulse-output mode a toggle flip-flop inverts its output. The byte access sequencer has three named states. ACC_IDLE is the resting state. A low-byte write moves it to ACC_LO_HELD, and a high-byte write returns it to ACC_IDLE. A high-byte read moves it to ACC_HI_READ, and a low-byte read returns it to ACC_IDLE. In ACC_HI_READ a low-byte read returns the captured byte. In any other state it returns the live low byte.

Top module: `reload_timer16`

## Requirements
- R1: After reset the counter and latch read as 0x0000, the mode register reads 0x01 (stop set, all else clear), irq is 0, and pulse_out and pulse_oe are 0.
- R2: A write to the low byte address (reg_sel 0) alone changes neither the counter nor the latch.
- R3: A write to the high byte address (reg_sel 1) commits {high byte, held low byte}. With mode bit 1 (latch-only) clear, the value goes to both the latch and the counter.
- R4: With mode bit 1 set, a high-byte commit updates only the latch. The counter keeps its value, and the next reload uses the new latch value.
- R5: While mode bit 0 (stop) is clear, each active count pulse decrements a nonzero counter by one.
- R6: A count pulse while the counter is zero reloads the latch value and sets irq. irq stays set until irq_clr is high for a clock edge.
- R7: While mode bit 0 is set, count pulses are ignored and the counter keeps its value.
- R8: With mode bit 2 (external source) set, cntr_in edges are counted after a two-flop synchronizer. Mode bit 3 clear counts rising edges only. Mode bit 3 set counts falling edges only.
- R9: A read of the high byte returns counter bits 15:8 and captures bits 7:0. The next low-byte read returns the captured byte even if the counter has moved in between.
- R10: With mode bit 2 clear, the counter decrements once every 16 clocks.
- R11: Mode bit 4 enables pulse output. pulse_oe equals that bit, and any mode write loads the toggle with mode bit 3. pulse_out shows the toggle, which inverts on each underflow. pulse_out is 0 while bit 4 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register address: 0 low byte, 1 high byte, 2 mode |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (side effect: high-byte capture) |
| rd_data | output | 8 | Read data for the addressed register |
| cntr_in | input | 1 | External count pin input |
| irq_clr | input | 1 | Clears the interrupt request |
| irq | output | 1 | Sticky underflow interrupt request |
| pulse_out | output | 1 | Toggle output level |
| pulse_oe | output | 1 | Output enable for the toggle pin |

## Verification
The hardest situation to reach is a counter that moves between the two halves of a 16-bit read, because the captured low byte must then differ from the live one. The bench selects the external source so that each count pulse is an exact, deliberate cntr_in pulse. It reads the high byte, injects two edges, and only then reads the low byte. The same exact control is used to put a latch-only write just before a reload, and to step the toggle through several underflows. For the divide-by-16 source, the bench brackets a run window of exactly 16·k clocks between two mode writes, which makes the expected decrement exact whatever the prescaler phase is.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [1:0] SEL_LO   = 2'd0;
    localparam logic [1:0] SEL_HI   = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;

    typedef struct packed {
        logic pulse_en;    // bit 4
        logic edge_fall;   // bit 3
        logic src_ext;     // bit 2
        logic latch_only;  // bit 1
        logic stop;        // bit 0
    } mode_t;

    localparam mode_t MODE_RST = '{pulse_en: 1'b0, edge_fall: 1'b0, src_ext: 1'b0,
                                   latch_only: 1'b0, stop: 1'b1};

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_LO_HELD = 2'd1,
        ACC_HI_READ = 2'd2
    } acc_st_t;
endpackage

// File: rtl/tmr16_tick.sv
module tmr16_tick #(
    parameter int DIV  = 16,
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic edge_fall,
    input  logic pin_in,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int SW = SYNC + 1;

    logic [PW-1:0] pre;
    logic [SW-1:0] sh;
    logic          cur, prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (pre == PW'(DIV - 1)) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    generate
        if (SW > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[SW-2:0], pin_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= pin_in;
            end
        end
    endgenerate

    assign cur  = sh[SW-2];
    assign prev = sh[SW-1];

    always_comb begin
        if (src_ext) tick = edge_fall ? (prev & ~cur) : (~prev & cur);
        else         tick = (pre == PW'(DIV - 1));
    end
endmodule

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] cnt,
    output logic [BYTE_W-1:0] rd_data,
    output mode_t             mode,
    output logic [WORD_W-1:0] latch,
    output logic              cnt_wr,
    output logic [WORD_W-1:0] cnt_wr_val,
    output logic              mode_wr
);
    acc_st_t           state, nxt;
    logic [BYTE_W-1:0] hold_lo;
    logic [BYTE_W-1:0] cap_lo;
    logic              wr_lo, wr_hi, rd_lo, rd_hi;

    assign wr_lo   = wr_en && (reg_sel == SEL_LO);
    assign wr_hi   = wr_en && (reg_sel == SEL_HI);
    assign mode_wr = wr_en && (reg_sel == SEL_MODE);
    assign rd_lo   = rd_en && !wr_en && (reg_sel == SEL_LO);
    assign rd_hi   = rd_en && !wr_en && (reg_sel == SEL_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ACC_IDLE: begin
                if (wr_lo)      nxt = ACC_LO_HELD;
                else if (rd_hi) nxt = ACC_HI_READ;
            end
            ACC_LO_HELD: begin
                if (wr_hi)      nxt = ACC_IDLE;
                else if (rd_hi) nxt = ACC_HI_READ;
            end
            ACC_HI_READ: begin
                if (wr_lo)      nxt = ACC_LO_HELD;
                else if (rd_lo) nxt = ACC_IDLE;
            end
            default: nxt = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo <= '0;
            cap_lo  <= '0;
            latch   <= '0;
            mode    <= MODE_RST;
        end else begin
            if (wr_lo)   hold_lo <= wr_data;
            if (wr_hi)   latch   <= {wr_data, hold_lo};
            if (mode_wr) mode    <= mode_t'(wr_data[4:0]);
            if (rd_hi)   cap_lo  <= cnt[BYTE_W-1:0];
        end
    end

    always_comb begin
        cnt_wr     = wr_hi && !mode.latch_only;
        cnt_wr_val = {wr_data, hold_lo};
        unique case (reg_sel)
            SEL_LO:   rd_data = (state == ACC_HI_READ) ? cap_lo : cnt[BYTE_W-1:0];
            SEL_HI:   rd_data = cnt[WORD_W-1:BYTE_W];
            SEL_MODE: rd_data = {3'b000, mode};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              stop,
    input  logic              cnt_wr,
    input  logic [WORD_W-1:0] cnt_wr_val,
    input  logic [WORD_W-1:0] latch,
    input  logic              mode_wr,
    input  logic              init_lvl,
    input  logic              irq_clr,
    output logic [WORD_W-1:0] cnt,
    output logic              underflow,
    output logic              irq,
    output logic              tog
);
    logic step;

    assign step      = tick && !stop;
    assign underflow = step && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= cnt_wr_val;
        end else if (underflow) begin
            cnt <= latch;
        end else if (step) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            tog <= 1'b0;
        end else begin
            if (underflow)    irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
            if (mode_wr)        tog <= init_lvl;
            else if (underflow) tog <= ~tog;
        end
    end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
    import tmr16_pkg::*;
#(
    parameter int DIV  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       cntr_in,
    input  logic       irq_clr,
    output logic       irq,
    output logic       pulse_out,
    output logic       pulse_oe
);
    mode_t             mode;
    logic [WORD_W-1:0] latch, cnt, cnt_wr_val;
    logic              cnt_wr, mode_wr, tick, underflow, tog;

    tmr16_bytebus u_bus (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .cnt(cnt), .rd_data(rd_data),
        .mode(mode), .latch(latch), .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val),
        .mode_wr(mode_wr)
    );

    tmr16_tick #(.DIV(DIV), .SYNC(SYNC)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_ext(mode.src_ext),
        .edge_fall(mode.edge_fall), .pin_in(cntr_in), .tick(tick)
    );

    tmr16_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stop(mode.stop),
        .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val), .latch(latch),
        .mode_wr(mode_wr), .init_lvl(wr_data[3]), .irq_clr(irq_clr),
        .cnt(cnt), .underflow(underflow), .irq(irq), .tog(tog)
    );

    assign pulse_oe  = mode.pulse_en;
    assign pulse_out = mode.pulse_en & tog;
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cnt,
    input logic [15:0] latch,
    input logic        stop,
    input logic        tick,
    input logic        underflow,
    input logic        cnt_wr,
    input logic        mode_wr,
    input logic        irq,
    input logic        tog,
    input logic        pulse_oe,
    input logic        pulse_out
);
    // R5: a running count pulse on a nonzero value steps down by one
    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop && !cnt_wr && cnt != 16'd0) |=> (cnt == $past(cnt) - 16'd1));

    // R6: an underflow reloads the latch and raises the request
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !cnt_wr) |=> (cnt == $past(latch)));
    a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> irq);

    // R7: halted counter keeps its value unless software commits one
    a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !cnt_wr) |=> $stable(cnt));

    // R11: toggle inverts on each underflow; output silent when disabled
    a_r11_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !mode_wr) |=> (tog != $past(tog)));
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_oe |-> !pulse_out);
endmodule

bind reload_timer16 reload_timer16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .latch(latch), .stop(mode.stop),
    .tick(tick), .underflow(underflow), .cnt_wr(cnt_wr), .mode_wr(mode_wr),
    .irq(irq), .tog(tog), .pulse_oe(pulse_oe), .pulse_out(pulse_out)
);

// File: tb/tb_reload_timer16.sv
module tb_reload_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       cntr_in = 1'b0;
    logic       irq_clr = 1'b0;
    logic       irq, pulse_out, pulse_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_timer16 dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .cntr_in(cntr_in),
        .irq_clr(irq_clr), .irq(irq), .pulse_out(pulse_out), .pulse_oe(pulse_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd1, h);
        rd(2'd0, l);
        v = {h, l};
    endtask

    task automatic pin_pulse();
        @(negedge clk); cntr_in = 1'b1;
        repeat (2) @(negedge clk);
        cntr_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_level(input logic v);
        @(negedge clk); cntr_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v; logic [7:0] m;
        rd16(v);          check("R1 counter", v, 16'h0000);
        rd(2'd2, m);      check("R1 mode", m, 8'h01);
        check("R1 irq", irq, 0);
        check("R1 pulse_out", pulse_out, 0);
        check("R1 pulse_oe", pulse_oe, 0);
    endtask

    task automatic t_write_order();
        logic [15:0] v;
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h34);
        rd16(v);          check("R2 low write alone", v, 16'h0000);
        wr(2'd1, 8'h12);
        rd16(v);          check("R3 commit", v, 16'h1234);
    endtask

    task automatic t_stop();
        logic [15:0] v;
        repeat (3) pin_pulse();
        rd16(v);          check("R7 stopped", v, 16'h1234);
    endtask

    task automatic t_count();
        logic [15:0] v;
        wr(2'd2, 8'h04);
        repeat (3) pin_pulse();
        rd16(v);          check("R5 three edges", v, 16'h1231);
    endtask

    task automatic t_coherent();
        logic [7:0] h, l; logic [15:0] v;
        rd(2'd1, h);      check("R9 high byte", h, 8'h12);
        repeat (2) pin_pulse();
        rd(2'd0, l);      check("R9 captured low", l, 8'h31);
        rd16(v);          check("R9 live value", v, 16'h122F);
    endtask

    task automatic t_latch_only();
        logic [15:0] v;
        wr(2'd2, 8'h05);
        wr16(16'h0001);
        wr(2'd2, 8'h07);
        wr16(16'h0005);
        rd16(v);          check("R4 counter kept", v, 16'h0001);
        wr(2'd2, 8'h04);
        pin_pulse();
        rd16(v);          check("R5 to zero", v, 16'h0000);
        check("R6 no irq yet", irq, 0);
        pin_pulse();
        rd16(v);          check("R4 reload new latch", v, 16'h0005);
        check("R6 irq set", irq, 1);
        pin_pulse();
        check("R6 irq sticky", irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R6 irq cleared", irq, 0);
        rd16(v);          check("R5 after reload", v, 16'h0004);
    endtask

    task automatic t_edges();
        logic [15:0] v;
        wr(2'd2, 8'h0C);
        pin_level(1'b1);
        rd16(v);          check("R8 rising ignored", v, 16'h0004);
        pin_level(1'b0);
        rd16(v);          check("R8 falling counted", v, 16'h0003);
    endtask

    task automatic t_pulse();
        wr(2'd2, 8'h1D);
        check("R11 oe", pulse_oe, 1);
        check("R11 init high", pulse_out, 1);
        wr16(16'h0001);
        wr(2'd2, 8'h1C);
        pin_level(1'b1); pin_level(1'b0);
        check("R11 no underflow", pulse_out, 1);
        pin_level(1'b1); pin_level(1'b0);
        check("R11 first toggle", pulse_out, 0);
        pin_level(1'b1); pin_level(1'b0);
        pin_level(1'b1); pin_level(1'b0);
        check("R11 second toggle", pulse_out, 1);
        wr(2'd2, 8'h15);
        check("R11 init low", pulse_out, 0);
        wr(2'd2, 8'h01);
        check("R11 oe off", pulse_oe, 0);
    endtask

    task automatic t_internal();
        logic [15:0] v;
        wr16(16'h0100);
        wr(2'd2, 8'h00);
        repeat (16 * 5 - 1) @(posedge clk);
        wr(2'd2, 8'h01);
        rd16(v);          check("R10 divide by 16", v, 16'h00FB);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_order();
        t_stop();
        t_count();
        t_coherent();
        t_latch_only();
        t_edges();
        t_pulse();
        t_internal();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule